// File: doc/BRIEF.md
# Time-Slot Serial Port

This block links a four-wire, frame-synchronised serial line to a processor-side buffer. A frame holds 32 time slots of 8 bits each. Each received slot becomes one byte, written into a receive buffer entry indexed by slot number. A transmit buffer entry supplies the byte shifted out during the matching slot. Bytes travel most significant bit first in both directions.

The serial side runs on one clock. This clock runs either at the bit rate or at twice the bit rate. In the double rate, each bit spans two cycles. A frame-sync pulse realigns the slot and bit position at any moment. Both buffers keep two banks. The serial side uses one bank while the processor uses the other, and the banks trade places at every frame start. Data written by the processor during one frame therefore goes out in the next frame. Bytes received during a frame can be read once the following frame start has occurred. A 32-bit slot mask switches individual slots off. A disabled slot leaves the line undriven and is not captured.

The processor port is synchronous and gives read data one cycle after the strobe. Every read word carries a programmable 8-bit prefix in its upper byte, so software can use the word directly as a table offset.

Top module: `tdm_slot_port`

## Requirements
- R1: A frame is 32 slots of 8 bits. The first bit period after a frame start is slot 0, bit 7. Slots follow in ascending order and wrap from 31 to 0 when no frame start arrives.
- R2: A frame start is a rising `fsync`, meaning high at a clock edge after being low at the previous edge. From the next cycle on, the position is slot 0, bit 7, wherever the frame was. A partly received byte is discarded.
- R3: Received bits are assembled MSB first. Each completed byte is stored in the receive entry of its slot, in the serial bank.
- R4: `line_out` carries the transmit byte of the current slot, MSB first, one bit per bit period, taken from the serial bank.
- R5: With `dbl_mode` = 1, each bit lasts two cycles. `line_out` holds the same value in both cycles. `line_in` is sampled only at the edge ending the second cycle. With `dbl_mode` = 0, each bit lasts one cycle.
- R6: A read returns its word in `cpu_rdata` one cycle after `cpu_rd`. The word is {prefix, byte}: the prefix in bits 15:8 and the addressed byte in bits 7:0. `cpu_rdata` keeps its value while no read is made.
- R7: The address map uses `cpu_addr[6:5]` to pick the target and `cpu_addr[4:0]` to pick the slot. The targets are 00 = receive buffer, 01 = transmit buffer and 10 = prefix register. Reading the prefix register returns the prefix in both bytes. A write stores only `cpu_wdata[7:0]`, and bits 15:8 are ignored.
- R8: The processor always uses the bank that the serial side is not using. The banks swap at every frame start and at no other time. A final slot-31 byte that completes in the same cycle as a frame start goes into the bank that the processor then sees.
- R9: With `slot_en[s]` = 0, slot s has `line_oe` = 0 and its receive entry stays unchanged. With `slot_en[s]` = 1, `line_oe` = 1 during slot s.
- R10: After reset, all buffer entries, the prefix and `cpu_rdata` are zero. The serial side uses bank 0 at slot 0, bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial and processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbl_mode | input | 1 | 1: two clock cycles per bit |
| slot_en | input | 32 | Per-slot enable mask |
| fsync | input | 1 | Frame-sync input |
| line_in | input | 1 | Serial receive data |
| line_out | output | 1 | Serial transmit data |
| line_oe | output | 1 | Transmit output enable |
| cpu_addr | input | 7 | Target select and slot index |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 16 | Write data, only the low byte is used |
| cpu_rdata | output | 16 | Read data, one cycle after the strobe |

## Verification
The delicate coincidence is the last bit of slot 31 completing at the very edge where a frame start swaps the banks. The slot-31 byte must land in the old serial bank, which the processor owns from that edge on. Every frame in the bench raises `fsync` during the final bit period to force this coincidence, and then reads slot 31 through the processor port. A second case places a frame start in the middle of a byte during free running. After it, the bench checks that transmission restarts at slot 0, bit 7, and that every byte of the frame that follows is stored intact.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int SLOTS  = 32;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int BITS   = 8;
  localparam int BIT_W  = $clog2(BITS);
  localparam int NBANK  = 2;
  localparam int DATA_W = 2 * BITS;
  localparam int ADDR_W = SLOT_W + 2;

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic [BIT_W-1:0]  bidx;
    logic              half;
  } pos_t;

  localparam pos_t POS_START = '{slot: '0, bidx: BIT_W'(BITS - 1), half: 1'b0};

  typedef enum logic [1:0] {
    REG_RX   = 2'b00,
    REG_TX   = 2'b01,
    REG_PFX  = 2'b10,
    REG_NONE = 2'b11
  } region_e;

  // next serial position after one clock
  function automatic pos_t pos_step(input pos_t p, input logic dbl);
    pos_t n;
    n = p;
    if (dbl && !p.half) begin
      n.half = 1'b1;
    end else begin
      n.half = 1'b0;
      if (p.bidx == '0) begin
        n.bidx = BIT_W'(BITS - 1);
        n.slot = (p.slot == SLOT_W'(SLOTS - 1)) ? '0 : p.slot + 1'b1;
      end else begin
        n.bidx = p.bidx - 1'b1;
      end
    end
    return n;
  endfunction

  // true in the cycle whose closing edge samples the line
  function automatic logic bit_done(input pos_t p, input logic dbl);
    return dbl ? p.half : 1'b1;
  endfunction

  function automatic region_e addr_region(input logic [ADDR_W-1:0] a);
    return region_e'(a[ADDR_W-1 -: 2]);
  endfunction

  function automatic logic [DATA_W-1:0] rd_word(input logic [BITS-1:0] pfx,
                                                input logic [BITS-1:0] b);
    return {pfx, b};
  endfunction
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer
  import tdm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fsync,
  input  logic dbl,
  output pos_t pos,
  output logic fs_evt,
  output logic sample_evt,
  output logic last_bit_evt,
  output logic ser_bank
);
  logic fsync_q;

  assign fs_evt       = fsync & ~fsync_q;
  assign sample_evt   = bit_done(pos, dbl);
  assign last_bit_evt = sample_evt && (pos.bidx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsync_q  <= 1'b0;
      pos      <= POS_START;
      ser_bank <= 1'b0;
    end else begin
      fsync_q  <= fsync;
      pos      <= fs_evt ? POS_START : pos_step(pos, dbl);
      ser_bank <= ser_bank ^ fs_evt;
    end
  end

  AST_FS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fs_evt |=> (pos == POS_START)); // R2
  AST_BANK_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    fs_evt |=> (ser_bank != $past(ser_bank))); // R8
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_evt |=> $stable(ser_bank)); // R8
  AST_SLOT_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (!fs_evt && last_bit_evt) |=> (pos.slot == $past(pos.slot) + 1'b1)); // R1
  AST_DBL_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl && !pos.half && !fs_evt) |=> (pos.half && $stable(pos.bidx))); // R5
endmodule

// File: rtl/tdm_dual_buf.sv
module tdm_dual_buf
  import tdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              w_bank,
  input  logic [SLOT_W-1:0] w_idx,
  input  logic [BITS-1:0]   w_data,
  input  logic              a_bank,
  input  logic [SLOT_W-1:0] a_idx,
  output logic [BITS-1:0]   a_data,
  input  logic              b_bank,
  input  logic [SLOT_W-1:0] b_idx,
  output logic [BITS-1:0]   b_data
);
  logic [BITS-1:0] rd_a [NBANK];
  logic [BITS-1:0] rd_b [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [BITS-1:0] mem [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
      end else if (we && (w_bank == 1'(g))) begin
        mem[w_idx] <= w_data;
      end
    end

    assign rd_a[g] = mem[a_idx];
    assign rd_b[g] = mem[b_idx];
  end

  assign a_data = rd_a[a_bank];
  assign b_data = rd_b[b_bank];
endmodule

// File: rtl/tdm_rx_shift.sv
module tdm_rx_shift
  import tdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  pos_t              pos,
  input  logic              sample_evt,
  input  logic              last_bit_evt,
  input  logic              fs_evt,
  input  logic [SLOTS-1:0]  slot_en,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_idx,
  output logic [BITS-1:0]   wr_byte
);
  logic [BITS-2:0] sh;

  assign wr_byte = {sh, line_in};
  assign wr_idx  = pos.slot;
  assign wr_en   = last_bit_evt && slot_en[pos.slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sh <= '0;
    else if (sample_evt) sh <= {sh[BITS-3:0], line_in};
    else if (fs_evt)     sh <= '0;
  end

  AST_SHIFT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |=> (sh[0] == $past(line_in))); // R3
endmodule

// File: rtl/tdm_cpu_port.sv
module tdm_cpu_port
  import tdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              tx_we,
  output logic [SLOT_W-1:0] idx,
  output logic [BITS-1:0]   wbyte,
  input  logic [BITS-1:0]   rx_byte,
  input  logic [BITS-1:0]   tx_byte
);
  region_e         region;
  logic [BITS-1:0] pfx;

  assign region = addr_region(addr);
  assign idx    = addr[SLOT_W-1:0];
  assign wbyte  = wdata[BITS-1:0];
  assign tx_we  = wr && (region == REG_TX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfx   <= '0;
      rdata <= '0;
    end else begin
      if (wr && (region == REG_PFX)) pfx <= wbyte;
      if (rd) begin
        case (region)
          REG_RX:  rdata <= rd_word(pfx, rx_byte);
          REG_TX:  rdata <= rd_word(pfx, tx_byte);
          REG_PFX: rdata <= rd_word(pfx, pfx);
          default: rdata <= rd_word(pfx, '0);
        endcase
      end
    end
  end

  AST_RD_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> (rdata[DATA_W-1:BITS] == $past(pfx))); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata)); // R6
  AST_PFX_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (region == REG_PFX)) |=> (pfx == $past(wdata[BITS-1:0]))); // R7
endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port
  import tdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbl_mode,
  input  logic [SLOTS-1:0]  slot_en,
  input  logic              fsync,
  input  logic              line_in,
  output logic              line_out,
  output logic              line_oe,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata
);
  pos_t              pos;
  logic              fs_evt, sample_evt, last_bit_evt, ser_bank, cpu_bank;
  logic              rx_we;
  logic [SLOT_W-1:0] rx_widx, cpu_idx;
  logic [BITS-1:0]   rx_wbyte, cpu_wbyte, rx_cpu_byte, tx_cpu_byte, tx_ser_byte;
  logic              tx_we;
  logic              echo_bank;
  logic [SLOT_W-1:0] echo_idx;
  logic [BITS-1:0]   rx_echo_byte;

  assign cpu_bank = ~ser_bank;

  tdm_slot_timer u_timer (
    .clk, .rst_n, .fsync, .dbl(dbl_mode), .pos, .fs_evt, .sample_evt,
    .last_bit_evt, .ser_bank
  );

  tdm_rx_shift u_rx (
    .clk, .rst_n, .line_in, .pos, .sample_evt, .last_bit_evt, .fs_evt,
    .slot_en, .wr_en(rx_we), .wr_idx(rx_widx), .wr_byte(rx_wbyte)
  );

  tdm_cpu_port u_cpu (
    .clk, .rst_n, .rd(cpu_rd), .wr(cpu_wr), .addr(cpu_addr), .wdata(cpu_wdata),
    .rdata(cpu_rdata), .tx_we, .idx(cpu_idx), .wbyte(cpu_wbyte),
    .rx_byte(rx_cpu_byte), .tx_byte(tx_cpu_byte)
  );

  // receive buffer: serial writes, processor reads; port b echoes the last write
  tdm_dual_buf u_rx_buf (
    .clk, .rst_n, .we(rx_we), .w_bank(ser_bank), .w_idx(rx_widx), .w_data(rx_wbyte),
    .a_bank(cpu_bank), .a_idx(cpu_idx), .a_data(rx_cpu_byte),
    .b_bank(echo_bank), .b_idx(echo_idx), .b_data(rx_echo_byte)
  );

  // transmit buffer: processor writes, serial and processor read
  tdm_dual_buf u_tx_buf (
    .clk, .rst_n, .we(tx_we), .w_bank(cpu_bank), .w_idx(cpu_idx), .w_data(cpu_wbyte),
    .a_bank(cpu_bank), .a_idx(cpu_idx), .a_data(tx_cpu_byte),
    .b_bank(ser_bank), .b_idx(pos.slot), .b_data(tx_ser_byte)
  );

  assign line_out = tx_ser_byte[pos.bidx];
  assign line_oe  = slot_en[pos.slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      echo_bank <= 1'b0;
      echo_idx  <= '0;
    end else if (rx_we) begin
      echo_bank <= ser_bank;
      echo_idx  <= rx_widx;
    end
  end

  AST_RX_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |=> (rx_echo_byte == $past(rx_wbyte))); // R3
  AST_RX_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> line_oe); // R9
  AST_TX_HOLD_DBL: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_mode && pos.half && $stable(dbl_mode) && !$past(fs_evt)) |-> $stable(line_out)); // R5
  AST_TX_WR_CPU_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    tx_we |=> (tx_cpu_byte == $past(cpu_wbyte) || cpu_idx != $past(cpu_idx)
               || ser_bank != $past(ser_bank))); // R7
endmodule

// File: tb/tb_tdm_slot_port.sv
module tb_tdm_slot_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EN_MASK = 32'hFFFF_7FED; // slots 1, 4, 15 off
  localparam logic [15:0] SEED [8] = '{16'h3C96, 16'hA50F, 16'h7E21, 16'h18E7,
                                       16'hC35A, 16'h6B94, 16'hF00D, 16'h2DB4};

  logic        clk = 1'b0, rst_n = 1'b0, dbl_mode = 1'b0, fsync = 1'b0, line_in = 1'b0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [6:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        line_out, line_oe;
  logic [15:0] cpu_rdata;

  int   total = 0, bad = 0;
  logic done = 1'b0;
  logic [7:0] exp_rx [32];
  logic [7:0] pfx_m = 8'h00;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tdm_slot_port dut (
    .clk, .rst_n, .dbl_mode, .slot_en(EN_MASK), .fsync, .line_in, .line_out,
    .line_oe, .cpu_addr, .cpu_rd, .cpu_wr, .cpu_wdata, .cpu_rdata
  );

  function automatic logic [7:0] tx_pat(input int s, input logic [7:0] k);
    return SEED[s % 8][15:8] ^ 8'(s * 9) ^ k;
  endfunction

  function automatic logic [7:0] rx_pat(input int s, input logic [7:0] k);
    return (SEED[s % 8][7:0] + 8'(s * 5)) ^ k;
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cpu_write(input logic [6:0] a, input logic [15:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [6:0] a, output logic [15:0] d);
    cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic load_tx(input logic [7:0] k);
    for (int s = 0; s < 32; s++) cpu_write(7'(32 + s), {8'hEE, tx_pat(s, k)}); // R7 upper junk
  endtask

  task automatic frame_start();
    fsync = 1'b1;
    @(negedge clk);
  endtask

  // walks one frame of the slot table; the last bit coincides with the next frame start
  task automatic run_frame(input logic dbl, input logic [7:0] k);
    int per = dbl ? 2 : 1;
    int n   = 256 * per;
    for (int i = 0; i < n; i++) begin
      int s = i / (8 * per);
      int b = 7 - ((i / per) % 8);
      int h = i % per;
      logic [7:0] tb = tx_pat(s, k);
      logic [7:0] rb = rx_pat(s, k);
      chk("R9 line_oe", {15'd0, line_oe}, {15'd0, EN_MASK[s]});
      if (EN_MASK[s])
        chk((s == 0 && b == 7) ? "R1 first bit" : (dbl ? "R5 tx bit" : "R4 tx bit"),
            {15'd0, line_out}, {15'd0, tb[b]});
      line_in = (dbl && h == 0) ? ~rb[b] : rb[b]; // R5: first half carries the wrong bit
      fsync   = (i == n - 1);
      @(negedge clk);
    end
    fsync = 1'b0;
    for (int s = 0; s < 32; s++) if (EN_MASK[s]) exp_rx[s] = rx_pat(s, k);
  endtask

  task automatic check_rx(input string base);
    logic [15:0] d;
    for (int s = 0; s < 32; s++) begin
      cpu_read(7'(s), d);
      chk(!EN_MASK[s] ? "R9 disabled slot" : (s == 31 ? "R8 last slot" : base),
          d, {pfx_m, exp_rx[s]});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    for (int s = 0; s < 32; s++) exp_rx[s] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 rdata", cpu_rdata, 16'h0000);
    chk("R10 line_oe", {15'd0, line_oe}, 16'h0001);
    chk("R10 line_out", {15'd0, line_out}, 16'h0000);
    cpu_read(7'h40, d); chk("R10 prefix", d, 16'h0000);
    cpu_read(7'h03, d); chk("R10 rx entry", d, 16'h0000);

    // R7 prefix write keeps the low byte only
    cpu_write(7'h40, 16'h3CA5); pfx_m = 8'hA5;
    cpu_read(7'h40, d); chk("R7 prefix", d, 16'hA5A5);
    cpu_write(7'h60, 16'hFFFF); // unmapped target, no effect
    cpu_read(7'h40, d); chk("R7 unmapped", d, 16'hA5A5);

    // R6 read format and R7 upper byte dropped on buffer writes
    load_tx(8'h00);
    cpu_read(7'h25, d); chk("R6 tx readback", d, {8'hA5, tx_pat(5, 8'h00)});
    cpu_read(7'h3F, d); chk("R7 tx readback", d, {8'hA5, tx_pat(31, 8'h00)});
    d = cpu_rdata; @(negedge clk);
    chk("R6 rdata hold", cpu_rdata, d);

    // single-rate frame, R3 R4 R8
    frame_start();
    run_frame(1'b0, 8'h00);
    @(negedge clk);
    check_rx("R3 rx byte");

    // double-rate frame, R5
    dbl_mode = 1'b1;
    load_tx(8'h5A);
    frame_start();
    run_frame(1'b1, 8'h5A);
    @(negedge clk);
    check_rx("R5 rx byte");

    // R2 frame start in mid-byte during free running
    dbl_mode = 1'b0;
    load_tx(8'hC3);
    repeat (37) @(negedge clk);
    frame_start();
    run_frame(1'b0, 8'hC3);
    @(negedge clk);
    check_rx("R2 resync rx");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule